// File: doc/BRIEF.md
# Byte Translate and Test Engine

This engine walks a byte string held in a local string memory, one byte at a time and from the lowest address upward. Each string byte is used as an unsigned, zero-extended index into a 256-entry function table, and the entry read there is the byte's function byte. The engine runs in one of two modes, which are chosen when a run starts.

In translate mode, each string byte is overwritten in place by its function byte, and the whole field is processed. In test mode, the string is only read. Function bytes of zero are skipped, and the scan halts on the first nonzero one. The engine then reports that function byte and the string address of the argument that produced it, together with a 2-bit condition code.

A run is launched by a one-cycle start pulse that carries a mode, a base address and a length field. The length field holds one less than the number of bytes. Before a run, the host fills the table through a write stream and reads or writes the string through a second stream. Both streams use valid/ready. Ready is high only while the engine is idle, so any transfer offered during a run is held off until done.

Top module: `xlt_engine`

## Requirements
- R1: After reset, busy, done, cc, res_fn and res_addr are all zero, and both host streams are ready.
- R2: In translate mode (mode=0), the engine processes len_m1+1 bytes starting at base. Each byte at address a becomes table[str[a]]. Addresses wrap modulo the string depth. Bytes outside the field are unchanged.
- R3: In test mode (mode=1), no string byte is modified.
- R4: In test mode, the scan stops at the first byte whose function byte is nonzero. res_fn then takes that function byte, and res_addr takes that byte's string address.
- R5: A test-mode hit sets cc=1 if bytes remain after the hit byte, and cc=2 if the hit was on the last byte of the field. cc=3 never occurs.
- R6: A test-mode run with no nonzero function byte ends with cc=0. Every translate run also ends with cc=0. In both cases res_fn and res_addr keep their previous values.
- R7: Each processed byte takes three cycles. done is a one-cycle pulse in the cycle after the last processed byte's third cycle, so it comes 3n cycles after the start edge when n bytes are processed. busy is high from the start edge up to and including the done cycle. cc, res_fn and res_addr are updated when done rises.
- R8: A start pulse while busy is ignored. The running operation completes exactly as if that pulse had not occurred.
- R9: tw_ready and sp_ready equal the inverse of busy. An accepted string read (sp_we=0) returns sp_rdata with sp_rvalid high one cycle after acceptance.
- R10: len_m1=0 processes exactly one byte. len_m1=255 processes 256 bytes, wrapping past the top of the string memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled while idle |
| mode | input | 1 | 0 = translate, 1 = test |
| base | input | AW | String address of the first byte |
| len_m1 | input | 8 | Byte count minus one |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code (0 none, 1 hit with bytes left, 2 hit on last byte) |
| res_fn | output | 8 | Function byte of the last hit |
| res_addr | output | AW | String address of the last hit |
| tw_valid | input | 1 | Table write request |
| tw_ready | output | 1 | Table write accepted when high with tw_valid |
| tw_idx | input | 8 | Table entry index |
| tw_data | input | 8 | Table entry value |
| sp_valid | input | 1 | String access request |
| sp_ready | output | 1 | String access accepted when high with sp_valid |
| sp_we | input | 1 | 1 = write, 0 = read |
| sp_addr | input | AW | String address |
| sp_wdata | input | 8 | String write data |
| sp_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| sp_rdata | output | 8 | Read data |

## Verification
When a run processes n bytes, done is due exactly 3n edges after the start edge, and busy is due to fall on the edge that follows. cc and the result outputs change on the same edge that raises done. Read data arrives one edge after a read is accepted. The bench's reference model tracks these latencies as integer countdowns that it advances on the clock edge. Every output is compared against the model on the falling edge, so each result is sampled in the cycle it is due and never one cycle early or late.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int BYTE_W    = 8;
  localparam int TBL_DEPTH = 1 << BYTE_W;

  typedef enum logic {
    MODE_XLATE = 1'b0,
    MODE_TEST  = 1'b1
  } xlt_mode_e;

  typedef enum logic [1:0] {
    CC_NONE = 2'd0,
    CC_MORE = 2'd1,
    CC_LAST = 2'd2
  } xlt_cc_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_LK,
    S_AP,
    S_FIN
  } xlt_state_e;
endpackage

// File: rtl/xlt_ram.sv
module xlt_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 8,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // one asynchronous read port per consumer
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/xlt_seq.sv
module xlt_seq
  import xlt_pkg::*;
#(
  parameter int AW    = 9,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [AW-1:0]     base,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [BYTE_W-1:0] str_rdata,
  input  logic [BYTE_W-1:0] tbl_rdata,
  output logic [AW-1:0]     str_addr,
  output logic [BYTE_W-1:0] tbl_addr,
  output logic              str_we,
  output logic [BYTE_W-1:0] str_wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        cc,
  output logic [BYTE_W-1:0] res_fn,
  output logic [AW-1:0]     res_addr
);
  xlt_state_e        state;
  xlt_mode_e         mode_q;
  logic [AW-1:0]     ptr;
  logic [LEN_W-1:0]  remain;
  logic [BYTE_W-1:0] arg_q, fn_q, res_fn_q;
  logic [AW-1:0]     res_addr_q;
  xlt_cc_e           cc_q;
  logic              last_byte, hit;

  assign last_byte = (remain == '0);
  assign hit       = (mode_q == MODE_TEST) && (fn_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      mode_q     <= MODE_XLATE;
      ptr        <= '0;
      remain     <= '0;
      arg_q      <= '0;
      fn_q       <= '0;
      cc_q       <= CC_NONE;
      res_fn_q   <= '0;
      res_addr_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          mode_q <= xlt_mode_e'(mode);
          ptr    <= base;
          remain <= len_m1;
          state  <= S_RD;
        end
        S_RD: begin
          arg_q <= str_rdata;
          state <= S_LK;
        end
        S_LK: begin
          fn_q  <= tbl_rdata;
          state <= S_AP;
        end
        S_AP: begin
          if (hit) begin
            res_fn_q   <= fn_q;
            res_addr_q <= ptr;
            cc_q       <= last_byte ? CC_LAST : CC_MORE;
            state      <= S_FIN;
          end else if (last_byte) begin
            cc_q  <= CC_NONE;
            state <= S_FIN;
          end else begin
            ptr    <= ptr + 1'b1;
            remain <= remain - 1'b1;
            state  <= S_RD;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign str_addr  = ptr;
  assign tbl_addr  = arg_q;
  assign str_we    = (state == S_AP) && (mode_q == MODE_XLATE);
  assign str_wdata = fn_q;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign cc        = cc_q;
  assign res_fn    = res_fn_q;
  assign res_addr  = res_addr_q;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a run only begins from a start request
  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R8: the running mode cannot be altered by a new start mid-run
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(mode_q));

  // R5: reserved code never reported
  p_cc_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cc != 2'd3));

  // R4: a reported hit always carries a nonzero function byte
  p_hit_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cc != 2'd0) |-> (res_fn != '0));

  // R6: a run ending without a hit leaves the result untouched
  p_res_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cc == 2'd0) |-> ($stable(res_fn) && $stable(res_addr)));
endmodule

// File: rtl/xlt_engine.sv
module xlt_engine
  import xlt_pkg::*;
#(
  parameter int  STR_DEPTH = 512,
  localparam int AW        = $clog2(STR_DEPTH),
  localparam int LEN_W     = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [AW-1:0]     base,
  input  logic [LEN_W-1:0]  len_m1,
  output logic              busy,
  output logic              done,
  output logic [1:0]        cc,
  output logic [BYTE_W-1:0] res_fn,
  output logic [AW-1:0]     res_addr,
  input  logic              tw_valid,
  output logic              tw_ready,
  input  logic [BYTE_W-1:0] tw_idx,
  input  logic [BYTE_W-1:0] tw_data,
  input  logic              sp_valid,
  output logic              sp_ready,
  input  logic              sp_we,
  input  logic [AW-1:0]     sp_addr,
  input  logic [BYTE_W-1:0] sp_wdata,
  output logic              sp_rvalid,
  output logic [BYTE_W-1:0] sp_rdata
);
  logic [AW-1:0]         eng_addr;
  logic [BYTE_W-1:0]     eng_tbl_addr;
  logic                  eng_we;
  logic [BYTE_W-1:0]     eng_wdata;
  logic                  host_wr, host_rd, tbl_wr;
  logic                  str_we;
  logic [AW-1:0]         str_waddr;
  logic [BYTE_W-1:0]     str_wdata;
  logic [1:0][AW-1:0]    str_raddr;
  logic [1:0][BYTE_W-1:0] str_rdata;
  logic [0:0][BYTE_W-1:0] tbl_raddr;
  logic [0:0][BYTE_W-1:0] tbl_rdata;

  // host streams are only served while no run is active
  assign tw_ready = !busy;
  assign sp_ready = !busy;
  assign tbl_wr   = tw_valid && tw_ready;
  assign host_wr  = sp_valid && sp_ready && sp_we;
  assign host_rd  = sp_valid && sp_ready && !sp_we;

  assign str_we    = eng_we || host_wr;
  assign str_waddr = eng_we ? eng_addr  : sp_addr;
  assign str_wdata = eng_we ? eng_wdata : sp_wdata;
  assign str_raddr = {sp_addr, eng_addr};
  assign tbl_raddr = eng_tbl_addr;

  xlt_ram #(.DEPTH(STR_DEPTH), .W(BYTE_W), .NRD(2)) u_str (
    .clk   (clk),
    .we    (str_we),
    .waddr (str_waddr),
    .wdata (str_wdata),
    .raddr (str_raddr),
    .rdata (str_rdata)
  );

  xlt_ram #(.DEPTH(TBL_DEPTH), .W(BYTE_W), .NRD(1)) u_tbl (
    .clk   (clk),
    .we    (tbl_wr),
    .waddr (tw_idx),
    .wdata (tw_data),
    .raddr (tbl_raddr),
    .rdata (tbl_rdata)
  );

  xlt_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .base      (base),
    .len_m1    (len_m1),
    .str_rdata (str_rdata[0]),
    .tbl_rdata (tbl_rdata[0]),
    .str_addr  (eng_addr),
    .tbl_addr  (eng_tbl_addr),
    .str_we    (eng_we),
    .str_wdata (eng_wdata),
    .busy      (busy),
    .done      (done),
    .cc        (cc),
    .res_fn    (res_fn),
    .res_addr  (res_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_rvalid <= 1'b0;
      sp_rdata  <= '0;
    end else begin
      sp_rvalid <= host_rd;
      if (host_rd) sp_rdata <= str_rdata[1];
    end
  end

  // R9: an accepted read is answered on the next cycle
  p_rd_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> sp_rvalid);

  // R3: the string port is never written by the engine outside translate runs
  p_engine_write_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> (busy && !done && !host_wr));
endmodule

// File: tb/test_xlt_engine.sv
module test_xlt_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, mode = 1'b0;
  logic [8:0] base = '0;
  logic [7:0] len_m1 = '0;
  logic       busy, done;
  logic [1:0] cc;
  logic [7:0] res_fn;
  logic [8:0] res_addr;
  logic       tw_valid = 1'b0, tw_ready;
  logic [7:0] tw_idx = '0, tw_data = '0;
  logic       sp_valid = 1'b0, sp_ready, sp_we = 1'b0;
  logic [8:0] sp_addr = '0;
  logic [7:0] sp_wdata = '0;
  logic       sp_rvalid;
  logic [7:0] sp_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlt_engine #(.STR_DEPTH(DEPTH)) i_xlt_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .len_m1(len_m1), .busy(busy), .done(done), .cc(cc), .res_fn(res_fn),
    .res_addr(res_addr), .tw_valid(tw_valid), .tw_ready(tw_ready),
    .tw_idx(tw_idx), .tw_data(tw_data), .sp_valid(sp_valid),
    .sp_ready(sp_ready), .sp_we(sp_we), .sp_addr(sp_addr),
    .sp_wdata(sp_wdata), .sp_rvalid(sp_rvalid), .sp_rdata(sp_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_str [DEPTH];
  int m_tbl [256];
  int m_left = 0, m_cc = 0, m_fn = 0, m_addr = 0;
  int m_rvalid = 0, m_rdata = 0;
  int p_cc = 0, p_fn = 0, p_addr = 0;
  bit p_hit = 0, m_idle = 1;

  // returns processed byte count and fills the pending result
  function automatic int model_run(input int md, input int b, input int l);
    int n = 0;
    p_hit = 0;
    p_cc  = 0;
    for (int k = 0; k <= l; k++) begin
      int a = (b + k) % DEPTH;
      int f = m_tbl[m_str[a]];
      n++;
      if (md == 0) m_str[a] = f;
      else if (f != 0) begin
        p_hit = 1; p_fn = f; p_addr = a; p_cc = (k == l) ? 2 : 1;
        break;
      end
    end
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_cc = 0; m_fn = 0; m_addr = 0; m_rvalid = 0; m_rdata = 0;
    end else begin
      m_idle   = (m_left == 0);
      m_rvalid = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 1) begin
          m_cc = p_cc;
          if (p_hit) begin m_fn = p_fn; m_addr = p_addr; end
        end
      end
      if (m_idle) begin
        if (tw_valid) m_tbl[tw_idx] = tw_data;
        if (sp_valid) begin
          if (sp_we) m_str[sp_addr] = sp_wdata;
          else begin m_rvalid = 1; m_rdata = m_str[sp_addr]; end
        end
        if (start) m_left = 3 * model_run(mode, base, len_m1) + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R7 busy", busy, m_left > 0);
      chk("R7 done", done, m_left == 1);
      chk("R5 cc", cc, m_cc);
      chk("R4 res_fn", res_fn, m_fn);
      chk("R4 res_addr", res_addr, m_addr);
      chk("R9 sp_ready", sp_ready, m_left == 0);
      chk("R9 tw_ready", tw_ready, m_left == 0);
      chk("R9 sp_rvalid", sp_rvalid, m_rvalid);
      if (m_rvalid) chk("R9 sp_rdata", sp_rdata, m_rdata);
    end
  end

  // ---------------- drivers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic tbl_write(input int idx, input int data);
    tw_valid = 1; tw_idx = idx[7:0]; tw_data = data[7:0];
    tick();
    tw_valid = 0;
  endtask

  task automatic str_write(input int a, input int data);
    sp_valid = 1; sp_we = 1; sp_addr = a[8:0]; sp_wdata = data[7:0];
    tick();
    sp_valid = 0; sp_we = 0;
  endtask

  task automatic str_check(input string tag, input int a, input int exp);
    sp_valid = 1; sp_we = 0; sp_addr = a[8:0];
    tick();
    sp_valid = 0;
    chk(tag, sp_rdata, exp);
  endtask

  task automatic run(input string tag, input int md, input int b, input int l,
                     input int exp_cyc, input bit poke);
    int cyc = 0;
    start = 1; mode = md[0]; base = b[8:0]; len_m1 = l[7:0];
    tick();
    start = 0;
    while (!done && cyc < 4000) begin
      if (poke && cyc == 4) begin start = 1; mode = ~md[0]; base = 9'd0; end
      tick();
      start = 0;
      cyc++;
    end
    chk(tag, cyc, exp_cyc);
    tick();
  endtask

  function automatic int xl(input int v);
    return (v * 7 + 3) & 255;
  endfunction

  function automatic int orig(input int k);
    return (k * 17 + 1) & 255;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 cc", cc, 0);
    chk("R1 res_fn", res_fn, 0);
    chk("R1 res_addr", res_addr, 0);
    chk("R1 ready", {tw_ready, sp_ready}, 3);
    tick();

    // translate: R2, R6
    for (int i = 0; i < 256; i++) tbl_write(i, xl(i));
    for (int k = 0; k < 9; k++) str_write(10 + k, orig(k));
    run("R7 translate cycles", 0, 10, 7, 24, 0);
    chk("R6 translate cc", cc, 0);
    chk("R6 res kept", res_fn, 0);
    for (int k = 0; k < 8; k++) str_check("R2 translated byte", 10 + k, xl(orig(k)));
    str_check("R2 byte past field", 18, orig(8));

    // start while busy is ignored: R8
    for (int k = 0; k < 4; k++) str_write(100 + k, orig(k + 3));
    run("R8 cycles with mid-run start", 0, 100, 3, 12, 1);
    for (int k = 0; k < 4; k++) str_check("R8 translated byte", 100 + k, xl(orig(k + 3)));
    str_check("R8 address 0 untouched", 0, m_str[0]);

    // test mode table
    for (int i = 0; i < 256; i++) tbl_write(i, (i == 'h41) ? 'h99 : ((i == 'h5A) ? 'h07 : 0));
    str_write(200, 'h10); str_write(201, 'h20); str_write(202, 'h41);
    str_write(203, 'h30); str_write(204, 'h5A);

    run("R7 test hit cycles", 1, 200, 4, 9, 0);
    chk("R4 hit fn", res_fn, 'h99);
    chk("R4 hit addr", res_addr, 202);
    chk("R5 hit with bytes left", cc, 1);
    str_check("R3 string unchanged", 202, 'h41);
    str_check("R3 string unchanged", 204, 'h5A);

    run("R7 no-hit cycles", 1, 200, 1, 6, 0);
    chk("R6 no-hit cc", cc, 0);
    chk("R6 fn kept", res_fn, 'h99);
    chk("R6 addr kept", res_addr, 202);

    run("R7 last-hit cycles", 1, 203, 1, 6, 0);
    chk("R5 hit on last byte", cc, 2);
    chk("R4 last fn", res_fn, 'h07);
    chk("R4 last addr", res_addr, 204);

    run("R10 single byte cycles", 1, 202, 0, 3, 0);
    chk("R10 single byte cc", cc, 2);
    chk("R10 single byte addr", res_addr, 202);

    // full 256-byte field wrapping past the top
    for (int k = 0; k < 256; k++) str_write((400 + k) % DEPTH, (k == 255) ? 'h5A : 'h10);
    run("R10 full field cycles", 1, 400, 255, 768, 0);
    chk("R10 full field cc", cc, 2);
    chk("R10 wrapped addr", res_addr, (400 + 255) % DEPTH);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule